// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This coprocessor turns an 8x8 block of signed 8-bit pixels into its two-dimensional forward cosine transform using integer arithmetic only. A host on a small register bus loads the block one pixel at a time in row-major order. It starts the transform with a command write and polls a status register. It then unloads the 64 signed 16-bit coefficients in row-major order, two byte reads per coefficient.

The transform is separable. A row pass forms, for every block row and every horizontal frequency, a sum of pixel-times-cosine products. A column pass folds those partial sums with the vertical cosines and applies the final scale. Every cosine is an 8-bit value with 6 fractional bits, derived inside the block. Every product is renormalised by an arithmetic right shift of 6. One multiply-accumulate unit is shared by both passes, so a transform takes a fixed 1024 clock cycles.

Top module: `fdct_cop`

## Requirements
- R1: A bus write to address 0 while idle stores the pixel, multiplied by 64, at the current element index, and then advances the index by one. Elements are in row-major order, with element = 8*row + column.
- R2: The element index runs from 0 to 64. A push or a coefficient pop that finds the index at 64 first wraps it to 0, so a 65th push overwrites element 0 and a 65th pop returns element 0 again.
- R3: A bus write to address 2 with data bit 0 set, while idle, starts a transform. From the following cycle, a read of address 3 returns 1 in bit 0 for exactly 1024 clock cycles, and returns 0 otherwise.
- R4: Starting a transform resets the element index to 0 and the byte phase to upper, so the first pop after the transform returns the upper byte of element 0.
- R5: While a transform is running, command writes and pixel writes have no effect. The transform keeps its original length and the element index does not move.
- R6: The cosine for sample position p and frequency f is 64*cos((2p+1)*f*pi/16), truncated toward zero. For example, position 0 gives 64, 62, 59, 53, 45, 35, 24, 12 for frequencies 0 to 7.
- R7: For output (u,v), the row term is s[x] = sum over j of (in[x][j]*cos(j,v)) >>> 6. The column term is r = sum over x of (s[x]*cos(x,u)) >>> 6. All shifts are arithmetic and all accumulators are 32-bit signed.
- R8: The output is (r*k) >>> 12, truncated to 16-bit two's complement. Here k = (((16*Cu) >>> 6)*Cv) >>> 6, and Cu or Cv is 45 for frequency 0 and 64 otherwise. This gives k = 16, 11 or 7.
- R9: Each coefficient is read as two consecutive reads of address 1, upper byte first. Read data appears on bus_rdata the cycle after the read strobe and holds until the next read. Reads of address 0 or 2 return 0.
- R10: After reset the block is idle, bus_rdata is 0 and the element index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Register select: 0 pixel in, 1 coefficient out, 2 command, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters: 32-bit accumulators and a frequency-zero scale of 45. With these values all three scale factors (16, 11 and 7) and the full signed pixel range appear in the results. Blocks of all -128, checkerboards of 127 and -128, and impulses drive the 32-bit sums and the 16-bit truncation to their largest magnitudes. The bench compares the results bit-exactly against a reference whose cosines it derives from floating-point cosine. Separate sequences probe index wrap, index reset on start, commands and pushes during a transform, and the exact last busy cycle.

// File: rtl/fdct_pkg.sv
package fdct_pkg;

    localparam int N      = 8;
    localparam int NN     = N * N;
    localparam int BUS_W  = 8;
    localparam int FRAC   = 6;
    localparam int COEF_W = 8;
    localparam int IDX_W  = $clog2(NN + 1);
    localparam int POS_W  = $clog2(N);
    localparam int CNT_W  = 3 * POS_W;
    localparam int BUSY_CYCLES = 2 * NN * N;

    localparam logic [1:0] A_PIX  = 2'd0;
    localparam logic [1:0] A_RES  = 2'd1;
    localparam logic [1:0] A_CMD  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2
    } phase_e;

    // magnitude of 64*cos(k*pi/16) for k in 0..8
    function automatic int cos_mag(input int k);
        case (k)
            0: return 64;
            1: return 62;
            2: return 59;
            3: return 53;
            4: return 45;
            5: return 35;
            6: return 24;
            7: return 12;
            default: return 0;
        endcase
    endfunction

    // fold the angle (2p+1)f modulo a full turn into the first quadrant
    function automatic logic signed [COEF_W-1:0] cos_coef(input logic [POS_W-1:0] pos,
                                                          input logic [POS_W-1:0] freq);
        int a;
        int m;
        a = ((2 * int'(pos) + 1) * int'(freq)) % (4 * N);
        if (a <= N)            m =  cos_mag(a);
        else if (a <= 2 * N)   m = -cos_mag(2 * N - a);
        else if (a <= 3 * N)   m = -cos_mag(a - 2 * N);
        else                   m =  cos_mag(4 * N - a);
        return COEF_W'(m);
    endfunction

endpackage

// File: rtl/fdct_cos_rom.sv
module fdct_cos_rom
    import fdct_pkg::*;
(
    input  logic [POS_W-1:0]         pos,
    input  logic [POS_W-1:0]         freq,
    output logic signed [COEF_W-1:0] coef
);

    always_comb begin
        coef = cos_coef(pos, freq);
    end

endmodule

// File: rtl/fdct_mac.sv
module fdct_mac
    import fdct_pkg::*;
#(
    parameter int ACC_W = 32
)(
    input  logic signed [ACC_W-1:0]  operand,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [ACC_W-1:0]  acc_in,
    output logic signed [ACC_W-1:0]  acc_out
);

    localparam int PROD_W = ACC_W + COEF_W;

    always_comb begin
        acc_out = acc_in
                + ACC_W'((PROD_W'(operand) * PROD_W'(coef)) >>> FRAC);
    end

endmodule

// File: rtl/fdct_scale.sv
module fdct_scale
    import fdct_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 16,
    parameter int C0_FIX = 45
)(
    input  logic signed [ACC_W-1:0] acc,
    input  logic                    dc_u,
    input  logic                    dc_v,
    output logic signed [OUT_W-1:0] res
);

    localparam int ONE     = 1 << FRAC;
    localparam int QUARTER = 1 << (FRAC - 2);
    localparam int K_W     = 16;
    localparam int PROD_W  = ACC_W + K_W;

    logic signed [K_W-1:0] k_fac;

    always_comb begin
        int cu;
        int cv;
        cu    = dc_u ? C0_FIX : ONE;
        cv    = dc_v ? C0_FIX : ONE;
        k_fac = K_W'((((QUARTER * cu) >>> FRAC) * cv) >>> FRAC);
        res   = OUT_W'((PROD_W'(acc) * PROD_W'(k_fac)) >>> (2 * FRAC));
    end

endmodule

// File: rtl/fdct_cop.sv
module fdct_cop
    import fdct_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int C0_FIX = 45
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);

    localparam int OUT_W  = 2 * BUS_W;
    localparam int IN_W   = BUS_W + FRAC;
    localparam int ADDR_W = 2 * POS_W;
    localparam logic [CNT_W-1:0] CNT_LAST = '1;
    localparam logic [POS_W-1:0] POS_LAST = '1;

    typedef struct packed {
        phase_e                  phase;
        logic [CNT_W-1:0]        cnt;
        logic [IDX_W-1:0]        idx;
        logic                    low_byte;
        logic signed [ACC_W-1:0] acc;
        logic [BUS_W-1:0]        rdata;
    } state_t;

    localparam state_t ST_RST = '{phase: PH_IDLE, default: '0};

    state_t st_d, st_q;

    logic signed [IN_W-1:0]  in_mem  [NN];
    logic signed [ACC_W-1:0] row_mem [NN];
    logic signed [OUT_W-1:0] out_mem [NN];

    logic                    in_we, row_we, out_we;
    logic [ADDR_W-1:0]       in_waddr;
    logic signed [IN_W-1:0]  in_wdata;

    logic [POS_W-1:0]        c_hi, c_mid, c_lo;
    logic                    row_pass;
    logic [POS_W-1:0]        rom_freq;
    logic signed [COEF_W-1:0] coef;
    logic signed [ACC_W-1:0] operand, mac_out;
    logic signed [OUT_W-1:0] scaled;
    logic [IDX_W-1:0]        eff_idx, pop_idx;
    logic                    busy;
    logic [IDX_W-1:0]        cur_idx;

    assign c_hi     = st_q.cnt[CNT_W-1 -: POS_W];
    assign c_mid    = st_q.cnt[2*POS_W-1 -: POS_W];
    assign c_lo     = st_q.cnt[POS_W-1:0];
    assign row_pass = (st_q.phase == PH_ROW);
    assign rom_freq = row_pass ? c_mid : c_hi;
    assign operand  = row_pass ? ACC_W'(in_mem[{c_hi, c_lo}])
                               : row_mem[{c_lo, c_mid}];
    assign busy     = (st_q.phase != PH_IDLE);
    assign cur_idx  = st_q.idx;
    assign bus_rdata = st_q.rdata;

    fdct_cos_rom u_rom (
        .pos  (c_lo),
        .freq (rom_freq),
        .coef (coef)
    );

    fdct_mac #(.ACC_W(ACC_W)) u_mac (
        .operand (operand),
        .coef    (coef),
        .acc_in  (st_q.acc),
        .acc_out (mac_out)
    );

    fdct_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .C0_FIX(C0_FIX)) u_scale (
        .acc  (mac_out),
        .dc_u (c_hi == '0),
        .dc_v (c_mid == '0),
        .res  (scaled)
    );

    always_comb begin
        st_d     = st_q;
        in_we    = 1'b0;
        row_we   = 1'b0;
        out_we   = 1'b0;
        eff_idx  = (st_q.idx == IDX_W'(NN)) ? '0 : st_q.idx;
        pop_idx  = st_q.low_byte ? st_q.idx : eff_idx;
        in_waddr = eff_idx[ADDR_W-1:0];
        in_wdata = {bus_wdata, {FRAC{1'b0}}};

        case (st_q.phase)
            PH_IDLE: begin
                if (bus_wr && bus_addr == A_PIX) begin
                    in_we         = 1'b1;
                    st_d.idx      = eff_idx + 1'b1;
                    st_d.low_byte = 1'b0;
                end else if (bus_wr && bus_addr == A_CMD && bus_wdata[0]) begin
                    st_d.phase    = PH_ROW;
                    st_d.cnt      = '0;
                    st_d.acc      = '0;
                    st_d.idx      = '0;
                    st_d.low_byte = 1'b0;
                end
                if (bus_rd) begin
                    case (bus_addr)
                        A_RES: begin
                            st_d.rdata    = st_q.low_byte
                                          ? out_mem[pop_idx[ADDR_W-1:0]][BUS_W-1:0]
                                          : out_mem[pop_idx[ADDR_W-1:0]][OUT_W-1:BUS_W];
                            st_d.idx      = st_q.low_byte ? pop_idx + 1'b1 : pop_idx;
                            st_d.low_byte = ~st_q.low_byte;
                        end
                        A_STAT:  st_d.rdata = '0;
                        default: st_d.rdata = '0;
                    endcase
                end
            end
            default: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (c_lo == POS_LAST) begin
                    st_d.acc = '0;
                    row_we   = row_pass;
                    out_we   = !row_pass;
                end else begin
                    st_d.acc = mac_out;
                end
                if (st_q.cnt == CNT_LAST) begin
                    st_d.phase = row_pass ? PH_COL : PH_IDLE;
                end
                if (bus_rd) begin
                    st_d.rdata = (bus_addr == A_STAT) ? BUS_W'(1) : '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (in_we)  in_mem[in_waddr]          <= in_wdata;
        if (row_we) row_mem[{c_hi, c_mid}]    <= mac_out;
        if (out_we) out_mem[{c_hi, c_mid}]    <= scaled;
    end

endmodule

// File: rtl/fdct_cop_chk.sv
module fdct_cop_chk
    import fdct_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic             cmd_bit,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             busy,
    input logic [IDX_W-1:0] idx
);

    localparam int SPAN_W = $clog2(BUSY_CYCLES + 2);

    logic [SPAN_W-1:0] span_q;
    logic              start_ok;

    assign start_ok = bus_wr && bus_addr == A_CMD && cmd_bit && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    span_q <= '0;
        else if (busy) span_q <= span_q + 1'b1;
        else           span_q <= '0;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> busy); // R3

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> span_q == SPAN_W'(BUSY_CYCLES)); // R3

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> span_q < SPAN_W'(BUSY_CYCLES)); // R5

    AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=> bus_rdata == BUS_W'($past(busy))); // R3

    AST_START_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> idx == '0); // R4

    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(NN)); // R2

    AST_BUSY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == A_PIX) |=> $stable(idx)); // R5

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

bind fdct_cop fdct_cop_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .cmd_bit   (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .idx       (cur_idx)
);

// File: tb/fdct_cop_bench.sv
`timescale 1ns/1ps
module fdct_cop_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    string cur_req = "R7";

    int cos_t [8][8];
    logic signed [15:0] exp_q [$];

    always #2.5 clk = ~clk;

    fdct_cop u_fdct_cop (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // monitor: collects byte pairs from coefficient pops and scores them
    logic       mon_rd = 1'b0;
    bit         mon_en = 1'b1;
    bit         have_hi = 1'b0;
    logic [7:0] hi_b;
    int         pop_no = 0;

    always @(posedge clk) mon_rd <= rst_n && mon_en && bus_rd && (bus_addr == 2'd1);

    always @(negedge clk) begin
        if (mon_rd) begin
            if (!have_hi) begin
                hi_b    = bus_rdata;
                have_hi = 1'b1;
            end else begin
                logic signed [15:0] got, e;
                have_hi = 1'b0;
                got = {hi_b, bus_rdata};
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL %s pop %0d: got %0d, expected nothing", cur_req, pop_no, got);
                end else begin
                    e = exp_q.pop_front();
                    if (got !== e) begin
                        failures++;
                        $display("FAIL %s pop %0d: got %0d expected %0d", cur_req, pop_no, got, e);
                    end
                end
                pop_no++;
            end
        end
    end

    // all bus tasks start and end on a falling edge
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // bit-exact integer reference of the transform (R6, R7, R8)
    task automatic expect_block(input int pix [64]);
        for (int u = 0; u < 8; u++) begin
            for (int v = 0; v < 8; v++) begin
                longint r = 0;
                longint k;
                int cu = (u == 0) ? 45 : 64;
                int cv = (v == 0) ? 45 : 64;
                for (int x = 0; x < 8; x++) begin
                    longint s = 0;
                    for (int j = 0; j < 8; j++)
                        s += (longint'(pix[x*8+j] * 64) * cos_t[j][v]) >>> 6;
                    r += (s * cos_t[x][u]) >>> 6;
                end
                k = (((16 * cu) >>> 6) * cv) >>> 6;
                exp_q.push_back(16'(((r * k) >>> 6) >>> 6));
            end
        end
    endtask

    task automatic push_block(input int pix [64]);
        for (int i = 0; i < 64; i++) bus_write(2'd0, 8'(pix[i]));
    endtask

    task automatic wait_done();
        logic [7:0] d;
        int n = 0;
        do begin
            bus_read(2'd3, d);
            n++;
        end while (d[0] && n < 3000);
        check("R3", int'(d), 0, "status after transform");
    endtask

    task automatic pop_pairs(input int n);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            bus_read(2'd1, d);
            bus_read(2'd1, d);
        end
        @(negedge clk);
    endtask

    task automatic run_block(input int pix [64], input string req);
        logic [7:0] d;
        cur_req = req;
        push_block(pix);
        expect_block(pix);
        bus_write(2'd2, 8'd1);
        bus_read(2'd3, d);
        check("R3", int'(d), 1, "status right after start");
        wait_done();
        pop_pairs(64);
        check("R9", exp_q.size(), 0, "coefficients left unread");
    endtask

    initial begin
        #750us;
        failures++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int pix [64];
        int pw [64];
        logic [7:0] d;
        logic signed [15:0] e0;
        logic [15:0] lfsr = 16'hACE1;

        for (int j = 0; j < 8; j++)
            for (int v = 0; v < 8; v++)
                cos_t[j][v] = $rtoi(64.0 * $cos(3.14159265358979 * (2*j+1) * v / 16.0));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10", int'(bus_rdata), 0, "rdata after reset");
        bus_read(2'd3, d);
        check("R10", int'(d), 0, "status after reset");
        bus_read(2'd0, d);
        check("R9", int'(d), 0, "read of pixel register");
        bus_read(2'd2, d);
        check("R9", int'(d), 0, "read of command register");

        // R1/R7: all-zero block
        for (int i = 0; i < 64; i++) pix[i] = 0;
        run_block(pix, "R1");

        // R8: flat block exercises the DC scale
        for (int i = 0; i < 64; i++) pix[i] = 100;
        run_block(pix, "R8");

        // R6: impulses expose single cosine rows and columns
        for (int i = 0; i < 64; i++) pix[i] = 0;
        pix[0] = 127; pix[29] = -128;
        run_block(pix, "R6");

        // R7: checkerboard of extreme values
        for (int i = 0; i < 64; i++) pix[i] = (((i / 8) + (i % 8)) % 2 != 0) ? 127 : -128;
        run_block(pix, "R7");

        // R7: ramp
        for (int i = 0; i < 64; i++) pix[i] = (i / 8) * 16 + (i % 8) * 2 - 64;
        run_block(pix, "R7");

        // R8: full negative block drives the largest DC magnitude
        for (int i = 0; i < 64; i++) pix[i] = -128;
        run_block(pix, "R8");

        // R7: pseudo-random block
        for (int i = 0; i < 64; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pix[i] = int'($signed(lfsr[7:0]));
        end
        run_block(pix, "R7");

        // R2 and R4: 65th push wraps onto element 0, start resets the index
        cur_req = "R2";
        for (int i = 0; i < 64; i++) pix[i] = ((i * 37) % 200) - 100;
        push_block(pix);
        bus_write(2'd0, 8'(-77));
        pw = pix;
        pw[0] = -77;
        expect_block(pw);
        e0 = exp_q[0];
        exp_q.push_back(e0);
        bus_write(2'd2, 8'd1);
        wait_done();
        pop_pairs(65);
        check("R2", exp_q.size(), 0, "coefficients left after wrap pops");

        // R4: a half-read coefficient, then a new start restarts at element 0 upper byte
        cur_req = "R4";
        mon_en = 1'b0;
        bus_read(2'd1, d);
        @(negedge clk);
        mon_en = 1'b1;
        expect_block(pw);
        bus_write(2'd2, 8'd1);
        wait_done();
        pop_pairs(64);
        check("R4", exp_q.size(), 0, "coefficients left after restart");

        // R5/R3: command and pixel writes during a transform are ignored
        cur_req = "R5";
        for (int i = 0; i < 64; i++) pix[i] = (i % 5) * 30 - 60;
        push_block(pix);
        expect_block(pix);
        bus_write(2'd2, 8'd1);
        repeat (500) @(negedge clk);
        bus_write(2'd2, 8'd1);
        bus_write(2'd0, 8'd55);
        repeat (521) @(negedge clk);
        bus_read(2'd3, d);
        check("R3", int'(d), 1, "status in last busy cycle");
        bus_read(2'd3, d);
        check("R5", int'(d), 0, "status one cycle later despite second command");
        pop_pairs(64);
        check("R5", exp_q.size(), 0, "coefficients left after busy writes");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule